// File: doc/BRIEF.md
# Three-Phase Complementary Gate Driver with Dead-Time Insertion

This block turns three single-ended pulse-width waveforms, one for each motor phase, into three complementary drive pairs. Each pair has a direct output that follows its phase input and an inverted output that follows the complement of that input. When the input changes, the output that has to switch off does so at once. The output that has to switch on waits until a per-phase gap has run out. As a result the two switches of one half-bridge are never driven on together.

Each phase has its own down-counter. The counter is loaded from that phase's gap value on every input edge and decrements once per count-enable tick, so the gap equals the gap value times the tick period. One counter serves both edge directions. If a new edge arrives while a gap is still running, the counter reloads and the pending switch-on is dropped. A pulse shorter than the gap therefore never reaches the output that was waiting. When the global arm input is low, every output is held off and every counter is cleared.

Top module: `deadband_trio`

## Requirements
- R1: While `rst` is high, all six bits of `drv_out` are 0.
- R2: When `arm` is sampled low at a clock edge, all of `drv_out` is 0 after that edge. After `arm` returns high, each pair stays at 0 until its input next changes.
- R3: Two clock edges after a rising input on phase i is presented, the inverted output `drv_out[2i+1]` is 0.
- R4: After a rising input on phase i, the direct output `drv_out[2i]` goes to 1 exactly G*P clock cycles after the edge at which `drv_out[2i+1]` was cleared, where G is `gap_len[i]` at that edge and P is the tick period.
- R5: On a falling input the roles swap. `drv_out[2i]` is 0 two edges after the change, and `drv_out[2i+1]` goes to 1 G*P cycles later.
- R6: If the input changes again before the gap has run out, the waiting output never turns on, and the counter restarts from `gap_len[i]` at the new edge.
- R7: When `gap_len[i]` is 0, the switch-on happens at the same edge as the switch-off.
- R8: The counter decrements only at edges where `tick` is 1.
- R9: Within one pair, `drv_out[2i]` and `drv_out[2i+1]` are never 1 at the same time.
- R10: Phase input `pwm_in[i]` affects only `drv_out[2i]` and `drv_out[2i+1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| tick | input | 1 | Count enable for the gap counters |
| arm | input | 1 | Enables dead-time operation; outputs are held off when low |
| gap_len | input | 3x16 | Gap value per phase, in ticks |
| pwm_in | input | 3 | Phase input waveforms |
| drv_out | output | 6 | Drive pairs; bit 2i is direct, bit 2i+1 is inverted |

## Verification
Each phase is driven with full rising and falling transitions across several gap values and tick periods: every cycle, every second cycle and every third cycle. These runs show whether the gap is measured in ticks or in clocks, and whether both edge directions share the same timing. A zero gap shows whether the switch-on coincides with the switch-off. A pulse narrower than the gap shows whether a pending switch-on is cancelled and whether the counter restarts from its full value rather than carrying on. Holding the other phases steady while one phase toggles shows whether the channels leak into each other. A disarm followed by a re-arm with the input held steady shows that the outputs clear and stay off until the next edge.

// File: rtl/deadband_pkg.sv
package deadband_pkg;
    localparam int DB_NCH = 3;
    localparam int DB_CW  = 16;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } edge_ev_t;
endpackage

// File: rtl/deadband_edge.sv
module deadband_edge
    import deadband_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    output edge_ev_t ev
);
    typedef struct packed {
        logic sync;
        logic prev;
    } edge_st_t;

    edge_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.sync = pin;
        st_d.prev = st_q.sync;
        ev.lvl    = st_q.sync;
        ev.rise   = st_q.sync & ~st_q.prev;
        ev.fall   = ~st_q.sync & st_q.prev;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/deadband_lane.sv
module deadband_lane
    import deadband_pkg::*;
#(
    parameter int CW = DB_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          arm,
    input  logic [CW-1:0] gap,
    input  edge_ev_t      ev,
    output logic          drv_dir,
    output logic          drv_inv
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          dir;
        logic          inv;
    } lane_st_t;

    lane_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!arm) begin
            st_d = '0;
        end else if (ev.rise) begin
            st_d.inv = 1'b0;
            st_d.cnt = gap;
            st_d.dir = (gap == '0);
        end else if (ev.fall) begin
            st_d.dir = 1'b0;
            st_d.cnt = gap;
            st_d.inv = (gap == '0);
        end else if (tick && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE;
            if (st_q.cnt == ONE) begin
                if (ev.lvl) st_d.dir = 1'b1;
                else        st_d.inv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign drv_dir = st_q.dir;
    assign drv_inv = st_q.inv;
endmodule

// File: rtl/deadband_trio.sv
module deadband_trio
    import deadband_pkg::*;
#(
    parameter int NCH = DB_NCH,
    parameter int CW  = DB_CW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    arm,
    input  logic [NCH-1:0][CW-1:0]  gap_len,
    input  logic [NCH-1:0]          pwm_in,
    output logic [2*NCH-1:0]        drv_out
);
    for (genvar i = 0; i < NCH; i++) begin : g_phase
        edge_ev_t ev;

        deadband_edge u_edge (
            .clk (clk),
            .rst (rst),
            .pin (pwm_in[i]),
            .ev  (ev)
        );

        deadband_lane #(.CW(CW)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .arm     (arm),
            .gap     (gap_len[i]),
            .ev      (ev),
            .drv_dir (drv_out[2*i]),
            .drv_inv (drv_out[2*i+1])
        );
    end
endmodule

// File: rtl/deadband_trio_chk.sv
module deadband_trio_chk #(
    parameter int NCH = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             arm,
    input logic [NCH-1:0]   pwm_in,
    input logic [2*NCH-1:0] drv_out
);
    assert_idle_when_disarmed_R2: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (drv_out == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R9
        assert_pair_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
            !(drv_out[2*i] && drv_out[2*i+1]));

        // R3
        assert_rise_clears_inverted_R3: assert property (@(posedge clk) disable iff (rst)
            ($past(pwm_in[i], 2) && !$past(pwm_in[i], 3)) |-> !drv_out[2*i+1]);

        // R5
        assert_fall_clears_direct_R5: assert property (@(posedge clk) disable iff (rst)
            (!$past(pwm_in[i], 2) && $past(pwm_in[i], 3)) |-> !drv_out[2*i]);
    end
endmodule

bind deadband_trio deadband_trio_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .arm     (arm),
    .pwm_in  (pwm_in),
    .drv_out (drv_out)
);

// File: tb/deadband_trio_test.sv
module deadband_trio_test;
    localparam int NCH = 3;
    localparam int CW  = 16;

    typedef struct packed {
        int ch;
        int gap;
        int per;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{0, 3, 1},
        '{1, 5, 1},
        '{2, 4, 3},
        '{0, 0, 1},
        '{1, 1, 2},
        '{2, 7, 2}
    };

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   tick = 1'b1;
    logic                   arm = 1'b0;
    logic [NCH-1:0][CW-1:0] gap_len = '0;
    logic [NCH-1:0]         pwm_in = '0;
    logic [2*NCH-1:0]       drv_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    deadband_trio #(.NCH(NCH), .CW(CW)) uut (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .arm     (arm),
        .gap_len (gap_len),
        .pwm_in  (pwm_in),
        .drv_out (drv_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drives phase ch to level lvl; posedge 1 samples it, posedge 2 acts on it.
    task automatic edge_run(input int ch, input logic lvl, input int gap, input int per, input string req);
        int on_b, off_b, want, on_at;
        bit bad;
        on_b  = lvl ? 2*ch : 2*ch+1;
        off_b = lvl ? 2*ch+1 : 2*ch;
        want  = 2 + gap*per;
        on_at = -1;
        bad   = 0;
        @(negedge clk);
        pwm_in[ch] = lvl;
        tick = 1'b0;
        for (int idx = 2; idx <= want + 4; idx++) begin
            @(negedge clk);
            tick = (idx > 2) && (((idx - 2) % per) == 0);
            if (idx - 1 >= 2 && drv_out[off_b]) bad = 1;
            if (drv_out[on_b] && drv_out[off_b]) bad = 1;
            if (on_at < 0 && drv_out[on_b]) on_at = idx - 1;
        end
        tick = 1'b1;
        check(!bad, req, int'(drv_out[off_b]), 0);
        check(on_at == want, req, on_at, want);
    endtask

    initial begin
        logic [2*NCH-1:0] snap;
        int on_at;
        bit bad;

        repeat (3) @(negedge clk);
        check(drv_out == '0, "R1", int'(drv_out), 0);
        rst = 1'b0;
        arm = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            int ch;
            logic [2*NCH-1:0] mask;
            ch = VECS[v].ch;
            mask = '0;
            mask[2*ch] = 1'b1;
            mask[2*ch+1] = 1'b1;
            gap_len[ch] = CW'(VECS[v].gap);
            snap = drv_out;
            edge_run(ch, 1'b1, VECS[v].gap, VECS[v].per,
                     VECS[v].gap == 0 ? "R7 rise" : (VECS[v].per > 1 ? "R8 R4 rise" : "R3 R4 rise"));
            edge_run(ch, 1'b0, VECS[v].gap, VECS[v].per,
                     VECS[v].gap == 0 ? "R7 fall" : "R5 fall");
            check((drv_out & ~mask) == (snap & ~mask), "R10", int'(drv_out & ~mask), int'(snap & ~mask));
        end

        // R6: high pulse of 4 cycles against a 10-tick gap on phase 0
        gap_len[0] = 16'd10;
        @(negedge clk);
        pwm_in[0] = 1'b1;
        on_at = -1;
        bad = 0;
        for (int idx = 2; idx <= 22; idx++) begin
            @(negedge clk);
            if (idx == 5) pwm_in[0] = 1'b0;
            if (drv_out[0]) bad = 1;
            if (idx - 1 >= 2 && on_at < 0 && drv_out[1]) on_at = idx - 1;
        end
        check(!bad, "R6 no pulse", int'(bad), 0);
        check(on_at == 16, "R6 restart", on_at, 16);

        // R2: disarm clears, re-arm keeps pairs off until an edge
        pwm_in[1] = 1'b1;
        repeat (12) @(negedge clk);
        arm = 1'b0;
        @(negedge clk);
        check(drv_out == '0, "R2 disarm", int'(drv_out), 0);
        arm = 1'b1;
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (drv_out != '0) bad = 1;
        end
        check(!bad, "R2 rearm idle", int'(drv_out), 0);
        gap_len[1] = 16'd2;
        edge_run(1, 1'b0, 2, 1, "R2 R5 after rearm");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule